// File: doc/BRIEF.md
# Interrupt Priority Chain with Status Save

This block arbitrates among a set of interrupt levels in a fixed priority order and, on the cycle it grants one, captures a two-word program status doubleword (PSD) for the surrounding sequencer to store. The levels fall into three groups: a small override group of internal levels, the ordinary internal levels, and the external levels. Requests are latched into pending bits. Each pending bit stays set until its level is granted or the bit is cleared explicitly.

The block also holds the running program's status. This is the protected-program flag, an internal inhibit, an external inhibit, overflow, carry, and the program counter. Setting an inhibit takes that class of levels out of the chain, so a lower-priority level of the other class can still win. Override levels ignore both inhibits. A grant sets both inhibits. A restore input reloads the whole status from a saved PSD. After each grant the block waits for an acknowledge before it makes another grant.

Level numbering: the override levels are 0 to N_OVR-1, the internal levels follow, and the external levels come last. A lower number has higher priority.

Top module: `irq_chain`

## Requirements
- R1: After reset no level is pending, `gnt` is 0, no grant is outstanding, and `cur_w1` and `cur_w2` are both zero.
- R2: A pulse on `irq_req[i]` sets pending bit i. The bit holds until level i is granted or `irq_clr[i]` is asserted. When request and clear arrive in the same cycle, the clear wins.
- R3: Among eligible pending levels the lowest level number is granted. This puts override levels before internal levels, and internal levels before external levels.
- R4: While the internal inhibit (word-one bit 14) is 1, ordinary internal levels are never granted, and a pending external level may be granted instead.
- R5: While the external inhibit (word-one bit 13) is 1, external levels are never granted.
- R6: Override levels are granted regardless of either inhibit.
- R7: `gnt` is a one-cycle pulse carrying `gnt_lvl`. It rises two clock edges after the request pulse when the level is eligible and nothing is outstanding.
- R8: `psd_w1` holds the pre-grant status with PP in bit 15, internal inhibit in bit 14, external inhibit in bit 13, overflow in bit 12, carry in bit 11, and zeros below. `psd_w2` holds the pre-grant program counter.
- R9: A grant sets both inhibit bits to 1 in the live status shown on `cur_w1`.
- R10: After a grant, no further grant is made until `ack` has been seen. An `ack` while nothing is outstanding has no effect.
- R11: `restore_vld` loads all five indicators from `restore_w1` (same bit layout as R8) and the program counter from `restore_w2`. No grant is made in a cycle with `restore_vld` high.
- R12: `run_upd` loads PP, overflow, carry and the program counter from `pp_in`, `ov_in`, `cy_in` and `pc_in`, leaving the inhibits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_OVR+N_INT+N_EXT | Request pulses, one per level |
| irq_clr | input | N_OVR+N_INT+N_EXT | Pending clear, one per level |
| ack | input | 1 | Acknowledge of the outstanding grant |
| run_upd | input | 1 | Load live PP, overflow, carry and PC |
| pp_in | input | 1 | Protected-program flag of the running program |
| ov_in | input | 1 | Overflow indicator |
| cy_in | input | 1 | Carry indicator |
| pc_in | input | 16 | Program counter |
| restore_vld | input | 1 | Reload status from a saved PSD |
| restore_w1 | input | 16 | PSD word one to restore |
| restore_w2 | input | 16 | PSD word two (PC) to restore |
| gnt | output | 1 | Grant pulse |
| gnt_lvl | output | $clog2(N_OVR+N_INT+N_EXT) | Granted level number |
| psd_w1 | output | 16 | Captured status word one |
| psd_w2 | output | 16 | Captured program counter |
| cur_w1 | output | 16 | Live status word one |
| cur_w2 | output | 16 | Live program counter |

## Verification
The assertions assume that the reserved low eleven bits of `restore_w1` are zero whenever `restore_vld` is high. They also assume that `restore_vld` and a grant never coincide, which the design enforces by blocking arbitration on restore. The bench only ever restores words whose reserved bits are zero. It raises `ack` only after it has seen a grant, except for one deliberate idle acknowledge. It drives `run_upd` only while no request is pending, so the captured status of every expected grant is fixed before the grant.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int WORD_W = 16;
    localparam int BIT_PP = 15;
    localparam int BIT_II = 14;
    localparam int BIT_EI = 13;
    localparam int BIT_OV = 12;
    localparam int BIT_CY = 11;
    localparam int RSV_W  = 11;

    typedef struct packed {
        logic              pp;
        logic              ii;
        logic              ei;
        logic              ov;
        logic              cy;
        logic [WORD_W-1:0] pc;
    } stat_t;

    function automatic logic [WORD_W-1:0] word_one(stat_t s);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[BIT_PP] = s.pp;
        w[BIT_II] = s.ii;
        w[BIT_EI] = s.ei;
        w[BIT_OV] = s.ov;
        w[BIT_CY] = s.cy;
        return w;
    endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int N_LVL = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] set_i,
    input  logic [N_LVL-1:0] clr_i,
    input  logic [N_LVL-1:0] take_i,
    output logic [N_LVL-1:0] pend_o
);

    typedef struct packed {
        logic [N_LVL-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend | set_i) & ~clr_i & ~take_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2
    taken_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i != '0) |=> ((st_q.pend & $past(take_i)) == '0));

    // R2
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((st_q.pend & $past(clr_i)) == '0));

endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
    parameter int N_OVR = 2,
    parameter int N_INT = 4,
    parameter int N_EXT = 8,
    localparam int N_LVL = N_OVR + N_INT + N_EXT,
    localparam int LVL_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] pend_i,
    input  logic             ii_i,
    input  logic             ei_i,
    input  logic             allow_i,
    output logic             hit_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic [N_LVL-1:0] oh_o
);

    localparam int EXT_LO = N_OVR + N_INT;

    logic [N_LVL-1:0] elig;

    for (genvar g = 0; g < N_LVL; g++) begin : g_elig
        if (g < N_OVR) begin : g_ovr
            assign elig[g] = pend_i[g];
        end else if (g < EXT_LO) begin : g_int
            assign elig[g] = pend_i[g] & ~ii_i;
        end else begin : g_ext
            assign elig[g] = pend_i[g] & ~ei_i;
        end
    end

    always_comb begin
        lvl_o = '0;
        for (int i = N_LVL - 1; i >= 0; i--) begin
            if (elig[i]) lvl_o = i[LVL_W-1:0];
        end
        hit_o        = allow_i && (elig != '0);
        oh_o         = '0;
        oh_o[lvl_o]  = hit_o;
    end

    // R3
    pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> pend_i[lvl_o]);

    // R3
    pick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oh_o));

    // R4
    int_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && ii_i && int'(lvl_o) >= N_OVR) |-> (int'(lvl_o) >= EXT_LO));

    // R5
    ext_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && ei_i) |-> (int'(lvl_o) < EXT_LO));

endmodule

// File: rtl/irq_status.sv
module irq_status
    import irq_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              pp_i,
    input  logic              ov_i,
    input  logic              cy_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_w1_i,
    input  logic [WORD_W-1:0] load_w2_i,
    input  logic              take_i,
    output stat_t             stat_o
);

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pp = load_w1_i[BIT_PP];
            st_d.ii = load_w1_i[BIT_II];
            st_d.ei = load_w1_i[BIT_EI];
            st_d.ov = load_w1_i[BIT_OV];
            st_d.cy = load_w1_i[BIT_CY];
            st_d.pc = load_w2_i;
        end else begin
            if (upd_i) begin
                st_d.pp = pp_i;
                st_d.ov = ov_i;
                st_d.cy = cy_i;
                st_d.pc = pc_i;
            end
            if (take_i) begin
                st_d.ii = 1'b1;
                st_d.ei = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q;

    // R9
    grant_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !load_i) |=> (st_q.ii && st_q.ei));

    // R11
    restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.pc == $past(load_w2_i) && st_q.ii == $past(load_w1_i[BIT_II])
                    && st_q.ei == $past(load_w1_i[BIT_EI])));

    // R11
    restore_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_w1_i[RSV_W-1:0] == '0));

    // R12
    upd_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i && !take_i) |=> (st_q.ii == $past(st_q.ii) && st_q.ei == $past(st_q.ei)));

endmodule

// File: rtl/irq_chain.sv
module irq_chain
    import irq_chain_pkg::*;
#(
    parameter int N_OVR = 2,
    parameter int N_INT = 4,
    parameter int N_EXT = 8,
    localparam int N_LVL = N_OVR + N_INT + N_EXT,
    localparam int LVL_W = $clog2(N_LVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  irq_req,
    input  logic [N_LVL-1:0]  irq_clr,
    input  logic              ack,
    input  logic              run_upd,
    input  logic              pp_in,
    input  logic              ov_in,
    input  logic              cy_in,
    input  logic [WORD_W-1:0] pc_in,
    input  logic              restore_vld,
    input  logic [WORD_W-1:0] restore_w1,
    input  logic [WORD_W-1:0] restore_w2,
    output logic              gnt,
    output logic [LVL_W-1:0]  gnt_lvl,
    output logic [WORD_W-1:0] psd_w1,
    output logic [WORD_W-1:0] psd_w2,
    output logic [WORD_W-1:0] cur_w1,
    output logic [WORD_W-1:0] cur_w2
);

    typedef struct packed {
        logic              busy;
        logic              gnt;
        logic [LVL_W-1:0]  lvl;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [N_LVL-1:0] pend;
    logic [N_LVL-1:0] pick_oh;
    logic [LVL_W-1:0] pick_lvl;
    logic             pick_hit;
    stat_t            stat;

    irq_pend #(.N_LVL(N_LVL)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_req),
        .clr_i  (irq_clr),
        .take_i (pick_oh),
        .pend_o (pend)
    );

    irq_arb #(.N_OVR(N_OVR), .N_INT(N_INT), .N_EXT(N_EXT)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .ii_i    (stat.ii),
        .ei_i    (stat.ei),
        .allow_i (!st_q.busy && !restore_vld),
        .hit_o   (pick_hit),
        .lvl_o   (pick_lvl),
        .oh_o    (pick_oh)
    );

    irq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (run_upd),
        .pp_i      (pp_in),
        .ov_i      (ov_in),
        .cy_i      (cy_in),
        .pc_i      (pc_in),
        .load_i    (restore_vld),
        .load_w1_i (restore_w1),
        .load_w2_i (restore_w2),
        .take_i    (pick_hit),
        .stat_o    (stat)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = pick_hit;
        if (pick_hit) begin
            st_d.busy = 1'b1;
            st_d.lvl  = pick_lvl;
            st_d.w1   = word_one(stat);
            st_d.w2   = stat.pc;
        end else if (ack) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt     = st_q.gnt;
    assign gnt_lvl = st_q.lvl;
    assign psd_w1  = st_q.w1;
    assign psd_w2  = st_q.w2;
    assign cur_w1  = word_one(stat);
    assign cur_w2  = stat.pc;

    // R7
    gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> !gnt);

    // R10
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !gnt);

    // R8
    psd_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (psd_w1[RSV_W-1:0] == '0));

    // R9
    gnt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (cur_w1[BIT_II] && cur_w1[BIT_EI]));

endmodule

// File: tb/irq_chain_bench.sv
module irq_chain_bench;

    localparam int NL = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_req = '0;
    logic [NL-1:0] irq_clr = '0;
    logic          ack = 1'b0;
    logic          run_upd = 1'b0;
    logic          pp_in = 1'b0, ov_in = 1'b0, cy_in = 1'b0;
    logic [15:0]   pc_in = '0;
    logic          restore_vld = 1'b0;
    logic [15:0]   restore_w1 = '0, restore_w2 = '0;
    logic          gnt;
    logic [3:0]    gnt_lvl;
    logic [15:0]   psd_w1, psd_w2, cur_w1, cur_w2;

    irq_chain u_irq_chain (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_clr(irq_clr), .ack(ack),
        .run_upd(run_upd), .pp_in(pp_in), .ov_in(ov_in), .cy_in(cy_in), .pc_in(pc_in),
        .restore_vld(restore_vld), .restore_w1(restore_w1), .restore_w2(restore_w2),
        .gnt(gnt), .gnt_lvl(gnt_lvl), .psd_w1(psd_w1), .psd_w2(psd_w2),
        .cur_w1(cur_w1), .cur_w2(cur_w2)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          lvl;
        logic [15:0] w1;
        logic [15:0] w2;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    logic gnt_prev = 1'b0;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(int lvl, logic [15:0] w1, logic [15:0] w2, string tag);
        exp_t e;
        e.lvl = lvl; e.w1 = w1; e.w2 = w2; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares each grant against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (gnt && gnt_prev) begin
                total++; bad++;
                $display("FAIL R7 grant wider than one cycle actual=1 expected=0");
            end
            if (gnt) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R10 unexpected grant actual=lvl%0d expected=none", gnt_lvl);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " lvl"}, {12'd0, gnt_lvl}, e.lvl[15:0]);
                    check({e.tag, " w1"}, psd_w1, e.w1);
                    check({e.tag, " w2"}, psd_w2, e.w2);
                end
            end
            gnt_prev = gnt;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(logic [NL-1:0] m);
        irq_req = m; tick(1); irq_req = '0;
    endtask

    task automatic pulse_clr(logic [NL-1:0] m);
        irq_clr = m; tick(1); irq_clr = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic do_restore(logic [15:0] w1, logic [15:0] w2);
        restore_vld = 1'b1; restore_w1 = w1; restore_w2 = w2;
        tick(1);
        restore_vld = 1'b0; restore_w1 = '0; restore_w2 = '0;
    endtask

    task automatic wait_gnt(string tag);
        bit seen = 0;
        for (int k = 0; k < 30 && !seen; k++) begin
            @(negedge clk);
            if (gnt) seen = 1;
        end
        if (!seen) begin
            total++; bad++;
            $display("FAIL %s no grant actual=0 expected=1", tag);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1
        check("R1 gnt", {15'd0, gnt}, 16'd0);
        check("R1 cur_w1", cur_w1, 16'h0000);
        check("R1 cur_w2", cur_w2, 16'h0000);

        // R12 live update: pp=1 ov=0 cy=1
        run_upd = 1'b1; pp_in = 1'b1; ov_in = 1'b0; cy_in = 1'b1; pc_in = 16'h1234;
        tick(1);
        run_upd = 1'b0;
        check("R12 cur_w1", cur_w1, 16'h8800);
        check("R12 cur_w2", cur_w2, 16'h1234);

        // R10 idle ack has no effect
        do_ack();
        tick(2);

        // R7 R8 external level with inhibits clear
        push(9, 16'h8800, 16'h1234, "R7 R8 ext9");
        pulse_req(NL'(1) << 9);
        wait_gnt("R7");
        // R9 inhibits set by the grant
        check("R9 cur_w1", cur_w1, 16'hE800);

        // R10 outstanding grant blocks even an override level
        pulse_req(NL'(1) << 0);
        tick(6);
        push(0, 16'hE800, 16'h1234, "R10 R6 ovr0");
        do_ack();
        wait_gnt("R10");
        do_ack();

        // R6 R5 R4 override wins while both inhibits are set
        push(1, 16'hE800, 16'h1234, "R6 ovr1");
        pulse_req((NL'(1) << 1) | (NL'(1) << 3) | (NL'(1) << 7));
        wait_gnt("R6");
        do_ack();
        tick(6);  // R4 R5: levels 3 and 7 stay masked

        // R11 restore: ii=1 ei=0 ov=1
        push(7, 16'h5000, 16'h0200, "R4 ext7 over int3");
        do_restore(16'h5000, 16'h0200);
        check("R11 cur_w1", cur_w1, 16'h5000);
        check("R11 cur_w2", cur_w2, 16'h0200);
        wait_gnt("R4");
        check("R9 cur_w1 after ext7", cur_w1, 16'h7000);
        do_ack();

        // R2 level 3 still latched
        push(3, 16'h0000, 16'h0300, "R2 int3 latched");
        do_restore(16'h0000, 16'h0300);
        wait_gnt("R2");
        do_ack();

        // R2 clear removes a pending request
        pulse_req(NL'(1) << 12);
        pulse_clr(NL'(1) << 12);
        do_restore(16'h0000, 16'h0400);
        tick(6);
        // R2 same-cycle request and clear: clear wins
        irq_req = NL'(1) << 11; irq_clr = NL'(1) << 11;
        tick(1);
        irq_req = '0; irq_clr = '0;
        tick(5);
        check("R2 no grant after clear", cur_w1, 16'h0000);
        push(11, 16'h0000, 16'h0400, "R2 ext11");
        pulse_req(NL'(1) << 11);
        wait_gnt("R2");
        do_ack();

        // R3 priority order across groups
        pulse_req((NL'(1) << 13) | (NL'(1) << 6) | (NL'(1) << 4) | (NL'(1) << 2));
        tick(2);
        push(2,  16'h0000, 16'h0500, "R3 first");
        do_restore(16'h0000, 16'h0500);
        wait_gnt("R3");
        do_ack();
        push(4,  16'h0000, 16'h0501, "R3 second");
        do_restore(16'h0000, 16'h0501);
        wait_gnt("R3");
        do_ack();
        push(6,  16'h0000, 16'h0502, "R3 third");
        do_restore(16'h0000, 16'h0502);
        wait_gnt("R3");
        do_ack();
        push(13, 16'h0000, 16'h0503, "R3 fourth");
        do_restore(16'h0000, 16'h0503);
        wait_gnt("R3");
        do_ack();
        do_restore(16'h0000, 16'h0600);
        tick(6);

        check("R7 scoreboard drained", 16'(exp_q.size()), 16'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule